// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block produces the serial clock for an I2C master whose SCL wire is shared, open-drain, with other masters. It alternates between pulling the line low for a programmed number of system clock cycles and releasing it for a programmed number of cycles. It watches the real level of the wire through a two-flop synchronizer, so the clock on the bus becomes the wired-AND of every master's clock.

The high-phase count only starts once the line is actually seen high. It is dropped the moment any other master pulls the line low. A master that releases early therefore waits for slower masters, and a master with a long high period is cut short by a faster one. The bus clock follows the longest low period and the shortest high period present. Two single-cycle strobes tell the attached data engine when the synchronized line rose or fell.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is held, `scl_pull_low`, `scl_rise` and `scl_fall` are all 0.
- R2: Each low phase keeps `scl_pull_low` at 1 for exactly `low_count` clock cycles. A value of 0 is treated as 1.
- R3: With no other master active, `scl_pull_low` stays 0 between low phases for exactly `high_count + 3` cycles. Of these, 2 cycles are synchronizer latency, 1 cycle is the observe step, and the rest is the high count (0 treated as 1).
- R4: When another master keeps the line low for X cycles beyond this master's release, the released interval grows to `X + high_count + 3` cycles. The high count does not begin until the synchronized line is high.
- R5: If the line is pulled low by another master during the high count, `scl_pull_low` becomes 1 at the third rising clock edge after `scl_in` fell. A full `low_count` low phase then follows.
- R6: `scl_rise` and `scl_fall` are each one cycle long. Each starts at the second rising clock edge after `scl_in` changes level.
- R7: When `enable` is 0, `scl_pull_low` is 0 in that same cycle and both strobes stay 0.
- R8: When `enable` returns to 1 with the line idle high, both counters start from zero. The first low phase begins exactly `high_count` cycles later.
- R9: After its own low phase, the block does not start a high count until the synchronized line has been seen low. A stale high level left in the synchronizer cannot shorten the released interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Clock generation on; 0 releases SCL and clears both counters |
| low_count | input | CNT_W | Low-phase length in clock cycles (0 acts as 1) |
| high_count | input | CNT_W | High-phase length in clock cycles (0 acts as 1) |
| scl_in | input | 1 | Raw level of the shared SCL wire |
| scl_pull_low | output | 1 | 1 drives the SCL wire low; 0 releases it |
| scl_rise | output | 1 | One-cycle strobe on a synchronized rising edge of SCL |
| scl_fall | output | 1 | One-cycle strobe on a synchronized falling edge of SCL |

## Verification
The bench models a second master on the wire in two ways. One version stretches the low phase by a fixed number of cycles. The other pulls the line low in the middle of a long high count. A design that started counting at its own release, instead of at the observed high, would give released intervals that ignore the stretch. A design that ignored the other master's pull would keep counting and miss the three-edge abort. Zero and one-cycle low counts are run to catch a controller that reads the stale high still in the synchronizer and shortens the released interval. The disable path is checked for an immediate release, silent strobes, and a counter that restarts at zero rather than resuming.

// File: rtl/scl_sync_pkg.sv
// Package: shared phase encoding for the SCL clock synchronizer.
// Assumes: only the three phases below are ever used by the controller.
package scl_sync_pkg;

    typedef enum logic [1:0] {
        PH_DRIVE_LOW  = 2'd0,   // pulling SCL low, low timer running
        PH_WAIT_HIGH  = 2'd1,   // released, waiting to see SCL high
        PH_COUNT_HIGH = 2'd2    // released and seen high, high timer running
    } phase_t;

endpackage

// File: rtl/scl_level_sync.sv
// Module: scl_level_sync
// Brings the asynchronous SCL wire level into the clock domain through a
// STAGES-deep flop chain and flags rising and falling edges of the result.
// Assumes: STAGES >= 2; the idle bus level is high, so the chain resets to 1.
module scl_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              level_d;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b1;
        end else begin
            level_d <= chain[STAGES-1];
        end
    end

    // Edge flags from the current and previous synchronized level.
    always_comb begin
        level = chain[STAGES-1];
        rise  = chain[STAGES-1] & ~level_d;
        fall  = ~chain[STAGES-1] & level_d;
    end

    // R6: an edge flag never lasts two cycles.
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/scl_phase_timer.sv
// Module: scl_phase_timer
// Up-counter for one clock phase. It counts while run is high and is forced
// to zero by clear. done is high in the cycle that completes the programmed
// length, so the phase lasts max(target,1) counting cycles.
// Assumes: the owner clears the counter whenever its phase is not active.
module scl_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] target,
    output logic             done
);

    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    // Count up while running, return to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt_next[CNT_W-1:0];
        end
    end

    // Completion when the cycle being counted reaches the target (0 acts as 1).
    always_comb begin
        cnt_next = {1'b0, cnt} + ONE;
        done     = run && (cnt_next >= {1'b0, target});
    end

    // R8: a cleared timer restarts from zero.
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/scl_clock_sync.sv
// Module: scl_clock_sync
// SCL generator for one master on a shared open-drain clock line. It pulls
// the line low for low_count cycles and then releases it. It waits until the
// synchronized line is seen high, then counts high_count cycles. The count is
// abandoned if another master pulls the line low first. The result is
// wired-AND clock synchronization.
// Assumes: scl_in is the raw wire level and the wire is low whenever
// scl_pull_low is 1.
module scl_clock_sync
    import scl_sync_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             scl_rise,
    output logic             scl_fall
);

    localparam int N_TIMERS = 2;

    phase_t state, state_nxt;
    logic   seen_low, seen_low_nxt;
    logic   bus_hi, bus_rise, bus_fall;
    logic [N_TIMERS-1:0] tmr_done;
    logic [CNT_W-1:0]    tmr_target [N_TIMERS];
    logic                low_done, high_done;

    scl_level_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .level (bus_hi),
        .rise  (bus_rise),
        .fall  (bus_fall)
    );

    // Route the programmed lengths to the two phase timers.
    always_comb begin
        tmr_target[0] = low_count;
        tmr_target[1] = high_count;
    end

    // One timer per counted phase: index 0 is the low phase, index 1 the high.
    for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_timer
        localparam phase_t OWN_PH = (gi == 0) ? PH_DRIVE_LOW : PH_COUNT_HIGH;
        scl_phase_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (!enable || (state != OWN_PH)),
            .run    (enable && (state == OWN_PH)),
            .target (tmr_target[gi]),
            .done   (tmr_done[gi])
        );
    end

    assign low_done  = tmr_done[0];
    assign high_done = tmr_done[1];

    // Phase sequencing: low count, wait for the bus high, high count or abort.
    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_DRIVE_LOW:  if (low_done) state_nxt = PH_WAIT_HIGH;
            PH_WAIT_HIGH:  if (seen_low && bus_hi) state_nxt = PH_COUNT_HIGH;
            PH_COUNT_HIGH: if (!bus_hi || high_done) state_nxt = PH_DRIVE_LOW;
            default:       state_nxt = PH_WAIT_HIGH;
        endcase
        if (!enable) begin
            state_nxt = PH_WAIT_HIGH;
        end
    end

    // Track whether the bus has gone low since this master last started a low phase.
    always_comb begin
        seen_low_nxt = seen_low;
        if (!enable) begin
            seen_low_nxt = 1'b1;
        end else if ((state_nxt == PH_DRIVE_LOW) && (state != PH_DRIVE_LOW)) begin
            seen_low_nxt = 1'b0;
        end else if (!bus_hi) begin
            seen_low_nxt = 1'b1;
        end
    end

    // Phase and low-seen registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_WAIT_HIGH;
            seen_low <= 1'b1;
        end else begin
            state    <= state_nxt;
            seen_low <= seen_low_nxt;
        end
    end

    // Outputs: drive low only in the low phase; strobes silenced when disabled.
    always_comb begin
        scl_pull_low = enable && (state == PH_DRIVE_LOW);
        scl_rise     = enable && bus_rise;
        scl_fall     = enable && bus_fall;
    end

    // R5: the bus going low during the high count forces a low phase next cycle.
    a_r5_abort_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == PH_COUNT_HIGH && !bus_hi) |=> (scl_pull_low || !enable));

    // R4: no high count starts while the synchronized bus is low.
    a_r4_wait_on_low_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == PH_WAIT_HIGH && !bus_hi) |=> (state != PH_COUNT_HIGH));

    // R2: a completed low count releases the line in the next cycle.
    a_r2_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == PH_DRIVE_LOW && low_done) |=> !scl_pull_low);

    // R6: rise and fall strobes never coincide.
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall));

    // R7: while disabled, the line is released and no strobe appears.
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!scl_pull_low && !scl_rise && !scl_fall));

endmodule

// File: tb/scl_clock_sync_tb.sv
module scl_clock_sync_tb;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] low_count = '0;
    logic [CW-1:0] high_count = '0;
    logic          other_a = 1'b0;   // stretching master
    logic          other_b = 1'b0;   // aborting master
    logic          scl_in;
    logic          scl_pull_low, scl_rise, scl_fall;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // scoreboard queues: expected low widths and expected released intervals
    int exp_low[$];
    int exp_gap[$];
    bit mon_en = 1'b0;
    bit solo = 1'b0;
    bit stretch_on = 1'b0;
    int stretch_x = 0;

    always #5 clk = ~clk;

    assign scl_in = ~(scl_pull_low | other_a | other_b);

    scl_clock_sync #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .low_count    (low_count),
        .high_count   (high_count),
        .scl_in       (scl_in),
        .scl_pull_low (scl_pull_low),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        #2;
    endtask

    // monitor: measures run lengths of scl_pull_low and compares with the queues
    int  run_len = 0;
    bit  prev_pull = 1'b0;
    bit  have_prev = 1'b0;
    bit  run_valid = 1'b0;
    int  since_up = 100;
    int  since_dn = 100;
    bit  last_pull = 1'b0;
    initial begin
        forever begin
            int e;
            sample();
            if (scl_pull_low && !last_pull) since_up = 1;
            else if (since_up < 100) since_up++;
            if (!scl_pull_low && last_pull) since_dn = 1;
            else if (since_dn < 100) since_dn++;
            last_pull = scl_pull_low;
            if (!mon_en) begin
                have_prev = 1'b0;
                run_valid = 1'b0;
            end else begin
                if (!have_prev) begin
                    prev_pull = scl_pull_low;
                    run_len = 1;
                    have_prev = 1'b1;
                end else if (scl_pull_low == prev_pull) begin
                    run_len++;
                end else begin
                    if (run_valid) begin
                        if (prev_pull) begin
                            if (exp_low.size() > 0) begin
                                e = exp_low.pop_front();
                                chk(run_len == e, "R2 low width", run_len, e);
                            end
                        end else if (exp_gap.size() > 0) begin
                            e = exp_gap.pop_front();
                            chk(run_len == e, "R3/R4 released interval", run_len, e);
                        end
                    end
                    run_valid = 1'b1;
                    prev_pull = scl_pull_low;
                    run_len = 1;
                end
                if (solo && scl_rise) chk(since_dn == 3, "R6 rise timing", since_dn, 3);
                if (solo && scl_fall) chk(since_up == 3, "R6 fall timing", since_up, 3);
            end
        end
    end

    // second master that holds SCL low stretch_x cycles past this master's release
    initial begin
        int hold;
        hold = 0;
        forever begin
            @(negedge clk);
            if (!stretch_on) begin
                other_a = 1'b0;
            end else if (scl_pull_low) begin
                other_a = 1'b1;
                hold = stretch_x;
            end else if (hold > 0) begin
                hold--;
            end else begin
                other_a = 1'b0;
            end
        end
    end

    task automatic stop_and_set(input int l, input int h);
        @(negedge clk);
        mon_en = 1'b0;
        solo = 1'b0;
        enable = 1'b0;
        low_count = l[CW-1:0];
        high_count = h[CW-1:0];
        repeat (6) @(negedge clk);
        exp_low.delete();
        exp_gap.delete();
    endtask

    task automatic run_scenario(input int l, input int h, input int n,
                                input bit is_solo, input int x, input string tag);
        int wl, wg, guard;
        stop_and_set(l, h);
        wl = (l == 0) ? 1 : l;
        wg = x + 3 + ((h == 0) ? 1 : h);
        for (int i = 0; i < n; i++) begin
            exp_low.push_back(wl);
            exp_gap.push_back(wg);
        end
        @(negedge clk);
        stretch_x = x;
        stretch_on = !is_solo;
        enable = 1'b1;
        solo = is_solo;
        mon_en = 1'b1;
        guard = 0;
        while ((exp_low.size() > 0 || exp_gap.size() > 0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_low.size() == 0 && exp_gap.size() == 0, tag,
            exp_low.size() + exp_gap.size(), 0);
        stretch_on = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int guard, strobes;
        // R1: reset state
        repeat (4) sample();
        chk(scl_pull_low == 1'b0, "R1 pull in reset", scl_pull_low, 0);
        chk(scl_rise == 1'b0, "R1 rise in reset", scl_rise, 0);
        chk(scl_fall == 1'b0, "R1 fall in reset", scl_fall, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3, R6: solo operation, two settings
        run_scenario(4, 5, 3, 1'b1, 0, "R3 solo 4/5 items done");
        run_scenario(7, 2, 3, 1'b1, 0, "R3 solo 7/2 items done");
        // R9: zero and one-cycle low counts must not be shortened by stale sync data
        run_scenario(0, 0, 3, 1'b1, 0, "R9 zero counts items done");
        run_scenario(1, 3, 3, 1'b1, 0, "R9 one-cycle low items done");
        // R4: another master stretches the low phase
        run_scenario(3, 4, 3, 1'b0, 6, "R4 stretched items done");
        run_scenario(5, 2, 2, 1'b0, 9, "R4 long stretch items done");

        // R5: another master pulls the line low during a long high count
        stop_and_set(3, 40);
        @(negedge clk);
        enable = 1'b1;
        guard = 0;
        do begin sample(); guard++; end while (!scl_pull_low && guard < 200);
        do begin sample(); guard++; end while (scl_pull_low && guard < 400);
        repeat (12) @(negedge clk);
        other_b = 1'b1;
        sample();
        chk(scl_pull_low == 1'b0, "R5 abort edge 1", scl_pull_low, 0);
        sample();
        chk(scl_pull_low == 1'b0, "R5 abort edge 2", scl_pull_low, 0);
        sample();
        chk(scl_pull_low == 1'b1, "R5 abort edge 3", scl_pull_low, 1);
        other_b = 1'b0;
        sample();
        sample();
        chk(scl_pull_low == 1'b1, "R5 full low after abort", scl_pull_low, 1);
        sample();
        chk(scl_pull_low == 1'b0, "R5 low ends after count", scl_pull_low, 0);

        // R7: disable in the middle of a low phase
        stop_and_set(20, 4);
        @(negedge clk);
        enable = 1'b1;
        guard = 0;
        do begin sample(); guard++; end while (!scl_pull_low && guard < 200);
        sample();
        @(negedge clk);
        enable = 1'b0;
        #2;
        chk(scl_pull_low == 1'b0, "R7 release on disable", scl_pull_low, 0);
        strobes = 0;
        for (int i = 0; i < 20; i++) begin
            sample();
            if (scl_rise || scl_fall || scl_pull_low) strobes++;
        end
        chk(strobes == 0, "R7 quiet while disabled", strobes, 0);

        // R8: re-enable on an idle bus restarts the high count from zero
        high_count = 8'd6;
        @(negedge clk);
        enable = 1'b1;
        for (int i = 1; i <= 6; i++) sample();
        chk(scl_pull_low == 1'b0, "R8 still released after H", scl_pull_low, 0);
        sample();
        chk(scl_pull_low == 1'b1, "R8 low phase after H", scl_pull_low, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule